// File: doc/BRIEF.md
# Integral Frequency Controller with Fixed-Point Accumulator

This block closes a frequency loop around a digitally tuned oscillator. Every time a fresh frequency count arrives with its valid strobe, it forms the signed difference between a requested count (the set point) and the measured count. It multiplies that difference by a programmable fractional gain and adds the product into a 16-bit accumulator that carries 8 fractional bits. The integer byte of the accumulator is then loaded into an output register that drives the oscillator's 8-bit control word.

The arithmetic is spread over four pipeline steps under a small sequencer, so the adder and multiplier never sit in one cycle of the fast clock. A single-cycle done flag marks each update of the control word. The set point comes from another clock domain and passes through a two-stage synchronizer before it is used. The gain and measurement are sampled only on the cycle that accepts the strobe.

Top module: `freq_integ_ctrl`

## Requirements
- R1: While rst_ni is low and right after its release, ctrl_word_o is 0, done_o is 0 and the accumulator is 0.
- R2: An accepted update computes acc_new = acc + (sp - meas) * gain. The error is signed 9-bit. gain_i is unsigned with 8 fractional bits (0x80 = 0.5). The accumulator is unsigned 16-bit with 8 fractional bits. ctrl_word_o becomes acc_new[15:8].
- R3: If the sum exceeds 0xFFFF the accumulator saturates at 0xFFFF (ctrl_word_o = 255) instead of wrapping.
- R4: If the sum goes below 0 the accumulator saturates at 0 (ctrl_word_o = 0) instead of wrapping.
- R5: A strobe is accepted when meas_valid_i is high at a rising edge while the block is idle. Counting that edge as edge 0, ctrl_word_o takes its new value and done_o goes high at edge 4. done_o stays high for exactly one cycle.
- R6: A strobe that arrives while an update is in progress (edges 1 to 4) is ignored. Changes to meas_i or gain_i after the accepting edge do not affect the running update.
- R7: ctrl_word_o changes only at the edge that raises done_o.
- R8: setpoint_i reaches the datapath through a two-flop synchronizer. The update accepted at edge n uses the setpoint_i value sampled at edge n-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| setpoint_i | input | 8 | Requested frequency count, asynchronous to clk_i |
| gain_i | input | 8 | Loop gain, unsigned, 8 fractional bits |
| meas_i | input | 8 | Measured frequency count |
| meas_valid_i | input | 1 | Strobe marking a new measurement |
| ctrl_word_o | output | 8 | Registered oscillator control word |
| done_o | output | 1 | One-cycle pulse when ctrl_word_o is updated |

## Verification
The bound checker watches several properties on every cycle:
- the fixed four-edge latency from acceptance to done and the single-cycle done pulse;
- that no strobe is accepted mid-update;
- that the control word holds still between updates;
- that each step moves the word in the direction of the error sign, with no wrap at either end of the range.

The exact numeric result of the fixed-point law, the synchronizer's two-edge set point delay, and the ignoring of late strobes and late gain changes need the bench's scenarios. There, a reference model tracks the accumulator across random and saturating sequences.

// File: rtl/fic_pkg.sv
package fic_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ERR  = 3'd1,
    ST_MUL  = 3'd2,
    ST_ACC  = 3'd3,
    ST_OUT  = 3'd4
  } fic_state_e;
endpackage

// File: rtl/fic_sync.sv
module fic_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fic_seq.sv
module fic_seq
  import fic_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic accept_o,
  output logic ld_err_o,
  output logic ld_prod_o,
  output logic ld_acc_o,
  output logic ld_out_o
);
  fic_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (valid_i) state_d = ST_ERR;
      ST_ERR:  state_d = ST_MUL;
      ST_MUL:  state_d = ST_ACC;
      ST_ACC:  state_d = ST_OUT;
      ST_OUT:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  assign accept_o  = (state_q == ST_IDLE) && valid_i;
  assign ld_err_o  = (state_q == ST_ERR);
  assign ld_prod_o = (state_q == ST_MUL);
  assign ld_acc_o  = (state_q == ST_ACC);
  assign ld_out_o  = (state_q == ST_OUT);
endmodule

// File: rtl/fic_datapath.sv
module fic_datapath #(
  parameter int CW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 accept_i,
  input  logic                 ld_err_i,
  input  logic                 ld_prod_i,
  input  logic                 ld_acc_i,
  input  logic                 ld_out_i,
  input  logic [CW-1:0]        sp_i,
  input  logic [CW-1:0]        meas_i,
  input  logic [CW-1:0]        gain_i,
  output logic signed [CW:0]   err_o,
  output logic [CW-1:0]        ctrl_o,
  output logic                 done_o
);
  localparam int FRAC   = CW;
  localparam int ERR_W  = CW + 1;
  localparam int PROD_W = 2*CW + 1;
  localparam int ACC_W  = CW + FRAC;
  localparam int SUM_W  = ACC_W + 2;

  logic [CW-1:0] sp_q, meas_q, gain_q;
  logic signed [ERR_W-1:0]  err_q;
  logic signed [PROD_W-1:0] prod_q;
  logic [ACC_W-1:0]         acc_q;
  logic [CW-1:0]            ctrl_q;
  logic                     done_q;

  logic signed [ERR_W-1:0]  err_d;
  logic signed [PROD_W-1:0] err_x, gain_x, prod_d;
  logic signed [SUM_W-1:0]  sum_d;
  logic [ACC_W-1:0]         acc_d;

  always_comb begin
    err_d  = $signed({1'b0, sp_q}) - $signed({1'b0, meas_q});
    err_x  = {{(PROD_W-ERR_W){err_q[ERR_W-1]}}, err_q};
    gain_x = {{(PROD_W-CW){1'b0}}, gain_q};
    prod_d = err_x * gain_x;
    sum_d  = $signed({2'b00, acc_q}) +
             $signed({{(SUM_W-PROD_W){prod_q[PROD_W-1]}}, prod_q});
    // saturate rather than wrap at both ends
    if (sum_d[SUM_W-1])      acc_d = '0;
    else if (sum_d[SUM_W-2]) acc_d = '1;
    else                     acc_d = sum_d[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= '0;
      meas_q <= '0;
      gain_q <= '0;
      err_q  <= '0;
      prod_q <= '0;
      acc_q  <= '0;
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (accept_i) begin
        sp_q   <= sp_i;
        meas_q <= meas_i;
        gain_q <= gain_i;
      end
      if (ld_err_i)  err_q  <= err_d;
      if (ld_prod_i) prod_q <= prod_d;
      if (ld_acc_i)  acc_q  <= acc_d;
      if (ld_out_i)  ctrl_q <= acc_q[ACC_W-1:FRAC];
      done_q <= ld_out_i;
    end
  end

  assign err_o  = err_q;
  assign ctrl_o = ctrl_q;
  assign done_o = done_q;
endmodule

// File: rtl/freq_integ_ctrl.sv
module freq_integ_ctrl #(
  parameter int CW       = 8,
  parameter int SYNC_STG = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] setpoint_i,
  input  logic [CW-1:0] gain_i,
  input  logic [CW-1:0] meas_i,
  input  logic          meas_valid_i,
  output logic [CW-1:0] ctrl_word_o,
  output logic          done_o
);
  logic [CW-1:0]      sp_sync;
  logic               accept, ld_err, ld_prod, ld_acc, ld_out;
  logic signed [CW:0] err_w;

  fic_sync #(.W(CW), .STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (setpoint_i),
    .q_o    (sp_sync)
  );

  fic_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (meas_valid_i),
    .accept_o  (accept),
    .ld_err_o  (ld_err),
    .ld_prod_o (ld_prod),
    .ld_acc_o  (ld_acc),
    .ld_out_o  (ld_out)
  );

  fic_datapath #(.CW(CW)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .ld_err_i  (ld_err),
    .ld_prod_i (ld_prod),
    .ld_acc_i  (ld_acc),
    .ld_out_i  (ld_out),
    .sp_i      (sp_sync),
    .meas_i    (meas_i),
    .gain_i    (gain_i),
    .err_o     (err_w),
    .ctrl_o    (ctrl_word_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/freq_integ_ctrl_chk.sv
module freq_integ_ctrl_chk #(
  parameter int CW = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               accept,
  input logic signed [CW:0] err_w,
  input logic [CW-1:0]      ctrl_word_o,
  input logic               done_o
);
  logic [2:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (accept) lat_q <= 3'd1;
    else if (lat_q == 3'd5) lat_q <= '0;
    else if (lat_q != '0) lat_q <= lat_q + 3'd1;
  end

  p_done_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == 3'd5);
  p_done_expected_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q == 3'd5 |-> done_o);
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (lat_q == 3'd0 || lat_q == 3'd5));
  p_out_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(ctrl_word_o));
  p_direction_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((err_w >= 0) ? (ctrl_word_o >= $past(ctrl_word_o))
                             : (ctrl_word_o <= $past(ctrl_word_o))));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(ctrl_word_o) == '1 && err_w >= 0) |-> ctrl_word_o == '1);
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(ctrl_word_o) == '0 && err_w <= 0) |-> ctrl_word_o == '0);
endmodule

bind freq_integ_ctrl freq_integ_ctrl_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .accept      (accept),
  .err_w       (err_w),
  .ctrl_word_o (ctrl_word_o),
  .done_o      (done_o)
);

// File: tb/freq_integ_ctrl_tb.sv
module freq_integ_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] setpoint_i = '0, gain_i = '0, meas_i = '0;
  logic       meas_valid_i = 1'b0;
  logic [7:0] ctrl_word_o;
  logic       done_o;

  int n_chk = 0, n_fail = 0;
  int acc_m = 0;

  always #2 clk_i = ~clk_i;

  freq_integ_ctrl u_dut (.*);

  function automatic int step_acc(int acc, int sp, int meas, int gain);
    int s;
    s = acc + (sp - meas) * gain;
    if (s < 0) s = 0;
    if (s > 65535) s = 65535;
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // runs one update with sp_used as the synchronized set point; returns after done pulse
  task automatic wait_update(int sp_used, int meas, int gain, string req);
    int n;
    logic [7:0] prev;
    bit moved;
    prev  = ctrl_word_o;
    moved = 1'b0;
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (!done_o && ctrl_word_o != prev) moved = 1'b1;
    end while (!done_o && n < 12);
    acc_m = step_acc(acc_m, sp_used, meas, gain);
    check(n == 4, "R5 latency", n, 4);
    check(ctrl_word_o == acc_m[15:8], req, ctrl_word_o, acc_m[15:8]);
    check(!moved, "R7 early change", moved, 0);
    @(negedge clk_i);
    check(!done_o, "R5 pulse width", done_o, 0);
  endtask

  task automatic do_update(int sp, int meas, int gain, string req);
    setpoint_i = sp[7:0];
    repeat (3) @(negedge clk_i);
    meas_i = meas[7:0];
    gain_i = gain[7:0];
    meas_valid_i = 1'b1;
    @(negedge clk_i);
    meas_valid_i = 1'b0;
    wait_update(sp, meas, gain, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int r;
    r = $urandom(32'd4711);
    repeat (3) @(negedge clk_i);
    check(ctrl_word_o == 0, "R1 reset word", ctrl_word_o, 0);
    check(!done_o, "R1 reset done", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(ctrl_word_o == 0 && !done_o, "R1 after release", ctrl_word_o, 0);

    // R2 directed: 100 - 60 = 40, gain 0x80 -> +20.0
    do_update(100, 60, 8'h80, "R2 basic");
    do_update(100, 60, 0, "R2 zero gain");
    do_update(10, 40, 8'h40, "R2 negative error");

    // R3: drive to saturation at the top
    for (int i = 0; i < 6; i++) do_update(255, 0, 255, "R3 overflow clamp");
    check(ctrl_word_o == 255, "R3 top value", ctrl_word_o, 255);
    // R4: drive to saturation at the bottom
    for (int i = 0; i < 6; i++) do_update(0, 255, 255, "R4 underflow clamp");
    check(ctrl_word_o == 0, "R4 bottom value", ctrl_word_o, 0);

    // R6: strobe and input changes during busy are ignored
    setpoint_i = 8'd200;
    repeat (3) @(negedge clk_i);
    meas_i = 8'd100; gain_i = 8'h40; meas_valid_i = 1'b1;
    @(negedge clk_i);
    meas_i = 8'd0; gain_i = 8'hFF;
    @(negedge clk_i);
    meas_valid_i = 1'b0;
    begin
      int n;
      n = 1;
      do begin @(negedge clk_i); n++; end while (!done_o && n < 12);
      acc_m = step_acc(acc_m, 200, 100, 8'h40);
      check(n == 4, "R6 latency with late strobe", n, 4);
      check(ctrl_word_o == acc_m[15:8], "R6 late inputs ignored", ctrl_word_o, acc_m[15:8]);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk_i);
        check(!done_o, "R6 no second update", done_o, 0);
      end
    end

    // R8: set point changed in the strobe cycle is not yet visible
    setpoint_i = 8'd50;
    repeat (4) @(negedge clk_i);
    setpoint_i = 8'd250;
    meas_i = 8'd50; gain_i = 8'hFF; meas_valid_i = 1'b1;
    @(negedge clk_i);
    meas_valid_i = 1'b0;
    wait_update(50, 50, 255, "R8 old set point used");
    // set two edges before strobe: new value used
    setpoint_i = 8'd90;
    @(negedge clk_i);
    @(negedge clk_i);
    meas_i = 8'd70; gain_i = 8'h80; meas_valid_i = 1'b1;
    @(negedge clk_i);
    meas_valid_i = 1'b0;
    wait_update(90, 70, 8'h80, "R8 new set point used");

    // random mix
    for (int i = 0; i < 60; i++) begin
      int sp, ms, g;
      sp = $urandom_range(255);
      ms = $urandom_range(255);
      g  = $urandom_range(255);
      do_update(sp, ms, g, "R2 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule